// File: doc/BRIEF.md
# Translation Cache with Walk-Level Rights Merging

This block keeps a small, fully associative set of virtual-to-physical page translations. A lookup port presents a virtual page number and receives, in the same cycle, a hit flag together with the physical frame, the merged write and user permissions, the merged no-execute bit, the dirty bit and the memory type. On a miss every data output reads zero.

A page walker outside the block offers each finished walk on a fill port with a valid/ready handshake. The fill port carries the per-level flags of up to four walk levels, with level 0 as the root. The block finds the level that maps the frame and rejects walks that are not cacheable. For a cacheable walk it merges the rights of every level it used. When any used level still has its accessed flag clear, it asks the walker to set those flags and installs the entry only after the walker acknowledges. Software-driven maintenance can drop one page or the whole set at any time.

Top module: `xlat_cache`

## Requirements
- R1: The stored write permission is the AND of the write flags of all used levels, and the stored user permission is the AND of the user flags of all used levels. Levels 0 through the final level are used.
- R2: The stored no-execute bit is the OR of the no-execute flags of the used levels when `nxe_i` is 1 at fill acceptance. When `nxe_i` is 0 it is 0.
- R3: The final level is the lowest-index level whose big-page flag is 1, or level 3 when there is none. Dirty and memory type are taken from the final level only (memory type of level l sits at `fill_mt_i[l*3 +: 3]`). Flags of levels below the final level have no effect.
- R4: An accepted fill in which any used level has its present flag at 0 or its reserved flag at 1 writes no entry. The port stays ready and raises no accessed request.
- R5: After an accepted cacheable fill, `acc_req_o` holds bit l set for each used level l whose accessed flag was 0, and `fill_ready_o` stays low until `acc_ack_i` is sampled 1. The entry is installed at that acknowledge edge. With no such level, the entry is installed at the acceptance edge and `acc_req_o` stays 0.
- R6: A lookup is combinational. It returns a hit with the entry's fields, or all outputs 0 on a miss. A lookup equal to the page of a fill accepted in that same cycle reports a miss.
- R7: An entry whose final level is not level 3 is a large page. It matches on VPN bits [19:9] only, and its returned frame takes bits [8:0] from the lookup VPN.
- R8: `inval_i` clears every entry that would hit `inval_vpn_i`, and `flush_i` clears all entries. Both take effect at the next edge. An entry installed on that same edge survives.
- R9: An install replaces an entry whose page range overlaps the new one, and clears any further overlapping entries. Otherwise it uses the lowest invalid slot. Otherwise it uses the slot at a round-robin pointer that starts at 0 and advances by one (mod 8) each time it is used. At most one entry hits any lookup.
- R10: After reset no entry is valid, `fill_ready_o` is 1 and `acc_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_vpn_i | input | 20 | Lookup virtual page number |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pfn_o | output | 24 | Physical frame on hit |
| lk_wr_o | output | 1 | Merged write permission |
| lk_usr_o | output | 1 | Merged user permission |
| lk_nx_o | output | 1 | Merged no-execute |
| lk_dirty_o | output | 1 | Dirty bit of final level |
| lk_mt_o | output | 3 | Memory type of final level |
| fill_valid_i | input | 1 | Fill offered |
| fill_ready_o | output | 1 | Fill port can accept |
| fill_vpn_i | input | 20 | Fill virtual page number |
| fill_pfn_i | input | 24 | Fill physical frame |
| fill_p_i | input | 4 | Per-level present flags |
| fill_rsvd_i | input | 4 | Per-level reserved-bit-set flags |
| fill_a_i | input | 4 | Per-level accessed flags |
| fill_wr_i | input | 4 | Per-level write flags |
| fill_usr_i | input | 4 | Per-level user flags |
| fill_nx_i | input | 4 | Per-level no-execute flags |
| fill_big_i | input | 4 | Per-level big-page flags |
| fill_dirty_i | input | 4 | Per-level dirty flags |
| fill_mt_i | input | 12 | Per-level memory types, 3 bits each |
| nxe_i | input | 1 | Global no-execute enable |
| acc_req_o | output | 4 | Levels whose accessed flag must be set |
| acc_ack_i | input | 1 | Walker confirms accessed flags set |
| inval_i | input | 1 | Invalidate one page |
| inval_vpn_i | input | 20 | Page to invalidate |
| flush_i | input | 1 | Clear all entries |

## Verification
The assertions watch, on every cycle, that no lookup ever matches two entries and that every install leaves its slot valid. They also watch that a flush empties the set and that the accessed-flag request stays steady while the port waits. A fill with an absent root level must never write. The actual merged rights, the choice of final level, the large-page frame splice, the round-robin victim order and invalidation by an address inside a large page can only be shown by the bench's scenarios. The bench compares each lookup against a model of the set kept from the requirements.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int unsigned VPN_W   = 20;
  parameter int unsigned PFN_W   = 24;
  parameter int unsigned LEVELS  = 4;
  parameter int unsigned ENTRIES = 8;
  parameter int unsigned MT_W    = 3;
  parameter int unsigned LP_BITS = 9;

  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned LVL_W = $clog2(LEVELS);

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic             big;
    logic [PFN_W-1:0] pfn;
    logic             wr;
    logic             usr;
    logic             nx;
    logic             dirty;
    logic [MT_W-1:0]  mt;
  } xl_entry_t;

  typedef enum logic {F_IDLE, F_WAIT} fill_st_e;
endpackage

// File: rtl/xlat_fill.sv
module xlat_fill
  import xlat_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fill_valid_i,
  output logic                   fill_ready_o,
  input  logic [VPN_W-1:0]       fill_vpn_i,
  input  logic [PFN_W-1:0]       fill_pfn_i,
  input  logic [LEVELS-1:0]      fill_p_i,
  input  logic [LEVELS-1:0]      fill_rsvd_i,
  input  logic [LEVELS-1:0]      fill_a_i,
  input  logic [LEVELS-1:0]      fill_wr_i,
  input  logic [LEVELS-1:0]      fill_usr_i,
  input  logic [LEVELS-1:0]      fill_nx_i,
  input  logic [LEVELS-1:0]      fill_big_i,
  input  logic [LEVELS-1:0]      fill_dirty_i,
  input  logic [LEVELS*MT_W-1:0] fill_mt_i,
  input  logic                   nxe_i,
  output logic [LEVELS-1:0]      acc_req_o,
  input  logic                   acc_ack_i,
  output logic                   wr_en_o,
  output xl_entry_t              wr_entry_o
);
  fill_st_e          st_q;
  xl_entry_t         hold_q, new_e;
  logic [LEVELS-1:0] mask_q, used, acc_mask;
  logic [LVL_W-1:0]  fin;
  logic              ok, accept;

  // final level: first big-page level from the root, else the leaf
  always_comb begin
    fin = LVL_W'(LEVELS-1);
    for (int l = LEVELS-1; l >= 0; l--)
      if (fill_big_i[l]) fin = LVL_W'(l);
    for (int l = 0; l < LEVELS; l++)
      used[l] = (l <= int'(fin));
  end

  assign ok       = &(~used | (fill_p_i & ~fill_rsvd_i));
  assign acc_mask = used & ~fill_a_i;

  always_comb begin
    new_e       = '0;
    new_e.vpn   = fill_vpn_i;
    new_e.pfn   = fill_pfn_i;
    new_e.big   = (fin != LVL_W'(LEVELS-1));
    new_e.wr    = &(fill_wr_i | ~used);
    new_e.usr   = &(fill_usr_i | ~used);
    new_e.nx    = nxe_i & (|(fill_nx_i & used));
    new_e.dirty = fill_dirty_i[fin];
    new_e.mt    = fill_mt_i[fin*MT_W +: MT_W];
  end

  assign fill_ready_o = (st_q == F_IDLE);
  assign accept       = fill_valid_i && fill_ready_o;
  assign acc_req_o    = (st_q == F_WAIT) ? mask_q : '0;
  assign wr_en_o      = ((st_q == F_WAIT) && acc_ack_i) || (accept && ok && (acc_mask == '0));
  assign wr_entry_o   = (st_q == F_WAIT) ? hold_q : new_e;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      mask_q <= '0;
      hold_q <= '0;
    end else if (st_q == F_IDLE) begin
      if (accept && ok && (acc_mask != '0)) begin
        st_q   <= F_WAIT;
        mask_q <= acc_mask;
        hold_q <= new_e;
      end
    end else if (acc_ack_i) begin
      st_q   <= F_IDLE;
      mask_q <= '0;
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fill_ready_o && !acc_ack_i) |=> (!fill_ready_o && $stable(acc_req_o)));
endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic             lk_kill_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] pfn_o,
  output xl_entry_t        ent_o,
  input  logic             wr_en_i,
  input  xl_entry_t        wr_entry_i,
  input  logic             inval_i,
  input  logic [VPN_W-1:0] inval_vpn_i,
  input  logic             flush_i
);
  xl_entry_t          ent_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, vld_nxt, hit_vec, inv_vec, ovl_vec;
  logic [IDX_W-1:0]   rr_q, victim;
  logic               use_rr, found;
  xl_entry_t          sel;

  function automatic logic pg_match(xl_entry_t e, logic [VPN_W-1:0] v);
    if (e.big) return e.vpn[VPN_W-1:LP_BITS] == v[VPN_W-1:LP_BITS];
    return e.vpn == v;
  endfunction

  function automatic logic pg_overlap(xl_entry_t e, xl_entry_t n);
    return (e.vpn[VPN_W-1:LP_BITS] == n.vpn[VPN_W-1:LP_BITS]) &&
           (e.big || n.big || (e.vpn[LP_BITS-1:0] == n.vpn[LP_BITS-1:0]));
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = vld_q[i] && pg_match(ent_q[i], lk_vpn_i);
    assign inv_vec[i] = vld_q[i] && pg_match(ent_q[i], inval_vpn_i);
    assign ovl_vec[i] = vld_q[i] && pg_overlap(ent_q[i], wr_entry_i);
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) sel = xl_entry_t'(sel | ent_q[i]);
  end

  assign hit_o = (|hit_vec) && !lk_kill_i;
  assign ent_o = hit_o ? sel : '0;
  assign pfn_o = !hit_o ? '0 :
                 sel.big ? {sel.pfn[PFN_W-1:LP_BITS], lk_vpn_i[LP_BITS-1:0]} : sel.pfn;

  // victim: overlapping entry, else lowest free slot, else round-robin
  always_comb begin
    victim = rr_q;
    use_rr = 1'b1;
    found  = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (!found && ovl_vec[i]) begin
        victim = IDX_W'(i); found = 1'b1; use_rr = 1'b0;
      end
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !vld_q[i]) begin
        victim = IDX_W'(i); found = 1'b1; use_rr = 1'b0;
      end
  end

  always_comb begin
    vld_nxt = vld_q;
    if (flush_i)      vld_nxt = '0;
    else if (inval_i) vld_nxt = vld_q & ~inv_vec;
    if (wr_en_i) begin
      vld_nxt         = vld_nxt & ~ovl_vec;
      vld_nxt[victim] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_nxt;
      if (wr_en_i && use_rr)
        rr_q <= (rr_q == IDX_W'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i)
    if (wr_en_i) ent_q[victim] <= wr_entry_i;

  // R9
  one_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(hit_vec));
  // R9
  install_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_q[$past(victim)]);
  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !wr_en_i) |=> (vld_q == '0));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [VPN_W-1:0]       lk_vpn_i,
  output logic                   lk_hit_o,
  output logic [PFN_W-1:0]       lk_pfn_o,
  output logic                   lk_wr_o,
  output logic                   lk_usr_o,
  output logic                   lk_nx_o,
  output logic                   lk_dirty_o,
  output logic [MT_W-1:0]        lk_mt_o,
  input  logic                   fill_valid_i,
  output logic                   fill_ready_o,
  input  logic [VPN_W-1:0]       fill_vpn_i,
  input  logic [PFN_W-1:0]       fill_pfn_i,
  input  logic [LEVELS-1:0]      fill_p_i,
  input  logic [LEVELS-1:0]      fill_rsvd_i,
  input  logic [LEVELS-1:0]      fill_a_i,
  input  logic [LEVELS-1:0]      fill_wr_i,
  input  logic [LEVELS-1:0]      fill_usr_i,
  input  logic [LEVELS-1:0]      fill_nx_i,
  input  logic [LEVELS-1:0]      fill_big_i,
  input  logic [LEVELS-1:0]      fill_dirty_i,
  input  logic [LEVELS*MT_W-1:0] fill_mt_i,
  input  logic                   nxe_i,
  output logic [LEVELS-1:0]      acc_req_o,
  input  logic                   acc_ack_i,
  input  logic                   inval_i,
  input  logic [VPN_W-1:0]       inval_vpn_i,
  input  logic                   flush_i
);
  logic      wr_en, lk_kill;
  xl_entry_t wr_entry, lk_ent;

  xlat_fill u_fill (
    .clk_i, .rst_ni, .fill_valid_i, .fill_ready_o, .fill_vpn_i, .fill_pfn_i,
    .fill_p_i, .fill_rsvd_i, .fill_a_i, .fill_wr_i, .fill_usr_i, .fill_nx_i,
    .fill_big_i, .fill_dirty_i, .fill_mt_i, .nxe_i, .acc_req_o, .acc_ack_i,
    .wr_en_o(wr_en), .wr_entry_o(wr_entry)
  );

  // same-cycle fill of the looked-up page reports a miss
  assign lk_kill = fill_valid_i && fill_ready_o && (lk_vpn_i == fill_vpn_i);

  xlat_store u_store (
    .clk_i, .rst_ni, .lk_vpn_i, .lk_kill_i(lk_kill), .hit_o(lk_hit_o),
    .pfn_o(lk_pfn_o), .ent_o(lk_ent), .wr_en_i(wr_en), .wr_entry_i(wr_entry),
    .inval_i, .inval_vpn_i, .flush_i
  );

  assign lk_wr_o    = lk_ent.wr;
  assign lk_usr_o   = lk_ent.usr;
  assign lk_nx_o    = lk_ent.nx;
  assign lk_dirty_o = lk_ent.dirty;
  assign lk_mt_o    = lk_ent.mt;

  // R4
  root_absent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_ready_o && !fill_p_i[0]) |-> !wr_en);
  // R4
  reject_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_ready_o && (fill_rsvd_i[0] || !fill_p_i[0])) |=> fill_ready_o);
endmodule

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
  import xlat_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [VPN_W-1:0] lk_vpn = '0, f_vpn = '0, inv_vpn = '0;
  logic [PFN_W-1:0] f_pfn = '0, lk_pfn;
  logic [LEVELS-1:0] f_p = '0, f_rsvd = '0, f_a = '0, f_wr = '0, f_usr = '0, f_nx = '0;
  logic [LEVELS-1:0] f_big = '0, f_dirty = '0, acc_req;
  logic [LEVELS*MT_W-1:0] f_mt = '0;
  logic f_valid = 0, nxe = 0, ack = 0, inv = 0, flush = 0;
  logic hit, lwr, lusr, lnx, ldirty, ready;
  logic [MT_W-1:0] lmt;

  xlat_cache u0 (
    .clk_i(clk), .rst_ni(rst_n), .lk_vpn_i(lk_vpn), .lk_hit_o(hit), .lk_pfn_o(lk_pfn),
    .lk_wr_o(lwr), .lk_usr_o(lusr), .lk_nx_o(lnx), .lk_dirty_o(ldirty), .lk_mt_o(lmt),
    .fill_valid_i(f_valid), .fill_ready_o(ready), .fill_vpn_i(f_vpn), .fill_pfn_i(f_pfn),
    .fill_p_i(f_p), .fill_rsvd_i(f_rsvd), .fill_a_i(f_a), .fill_wr_i(f_wr),
    .fill_usr_i(f_usr), .fill_nx_i(f_nx), .fill_big_i(f_big), .fill_dirty_i(f_dirty),
    .fill_mt_i(f_mt), .nxe_i(nxe), .acc_req_o(acc_req), .acc_ack_i(ack),
    .inval_i(inv), .inval_vpn_i(inv_vpn), .flush_i(flush)
  );

  int n_chk = 0, n_fail = 0;
  logic mv [ENTRIES];
  logic mbig [ENTRIES], mwr [ENTRIES], musr [ENTRIES], mnx [ENTRIES], md [ENTRIES];
  logic [VPN_W-1:0] mvpn [ENTRIES];
  logic [PFN_W-1:0] mpfn [ENTRIES];
  logic [MT_W-1:0]  mmt [ENTRIES];
  int mrr = 0;
  logic e_big, e_wr, e_usr, e_nx, e_d, e_ok;
  logic [MT_W-1:0] e_mt;
  logic [LEVELS-1:0] e_mask;

  task automatic chk(bit c, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] m_look(logic [VPN_W-1:0] v);
    logic [PFN_W-1:0] pf;
    for (int i = 0; i < ENTRIES; i++)
      if (mv[i] && (mbig[i] ? (mvpn[i][VPN_W-1:LP_BITS] == v[VPN_W-1:LP_BITS]) : (mvpn[i] == v))) begin
        pf = mbig[i] ? {mpfn[i][PFN_W-1:LP_BITS], v[LP_BITS-1:0]} : mpfn[i];
        return 64'({1'b1, pf, mwr[i], musr[i], mnx[i], md[i], mmt[i]});
      end
    return 64'd0;
  endfunction

  task automatic look(logic [VPN_W-1:0] v, string req);
    logic [63:0] act, exp;
    lk_vpn = v;
    #0.5;
    act = 64'({hit, lk_pfn, lwr, lusr, lnx, ldirty, lmt});
    exp = m_look(v);
    chk(act == exp, req, "lookup", act, exp);
  endtask

  // expected entry from the flags on the fill port
  task automatic derive();
    int fin;
    fin = LEVELS - 1;
    for (int l = LEVELS - 1; l >= 0; l--) if (f_big[l]) fin = l;
    e_ok = 1; e_mask = '0; e_wr = 1; e_usr = 1; e_nx = 0;
    for (int l = 0; l <= fin; l++) begin
      if (!f_p[l] || f_rsvd[l]) e_ok = 0;
      if (!f_a[l]) e_mask[l] = 1'b1;
      e_wr &= f_wr[l]; e_usr &= f_usr[l]; e_nx |= f_nx[l];
    end
    e_nx  = e_nx & nxe;
    e_d   = f_dirty[fin];
    e_mt  = f_mt[fin*MT_W +: MT_W];
    e_big = (fin != LEVELS - 1);
  endtask

  task automatic m_write(logic [VPN_W-1:0] v, logic [PFN_W-1:0] pf);
    int vic;
    vic = -1;
    for (int i = 0; i < ENTRIES; i++)
      if (mv[i] && (mvpn[i][VPN_W-1:LP_BITS] == v[VPN_W-1:LP_BITS]) &&
          (mbig[i] || e_big || (mvpn[i][LP_BITS-1:0] == v[LP_BITS-1:0]))) begin
        if (vic < 0) vic = i; else mv[i] = 0;
      end
    if (vic < 0)
      for (int i = 0; i < ENTRIES; i++) if (!mv[i]) begin vic = i; break; end
    if (vic < 0) begin vic = mrr; mrr = (mrr + 1) % ENTRIES; end
    mv[vic] = 1; mvpn[vic] = v; mpfn[vic] = pf; mbig[vic] = e_big;
    mwr[vic] = e_wr; musr[vic] = e_usr; mnx[vic] = e_nx; md[vic] = e_d; mmt[vic] = e_mt;
  endtask

  task automatic do_fill(int dly, string req);
    logic [VPN_W-1:0] v;
    logic [PFN_W-1:0] pf;
    @(negedge clk);
    f_valid = 1; v = f_vpn; pf = f_pfn;
    derive();
    lk_vpn = v; #0.5;
    chk(!hit && lk_pfn == '0, "R6", "same-cycle miss", 64'(hit), 64'd0);
    @(posedge clk); #0.5;
    f_valid = 0;
    if (!e_ok) begin
      chk(ready && acc_req == '0, "R4", "reject idle", 64'({ready, acc_req}), 64'({1'b1, 4'b0}));
    end else if (e_mask == '0) begin
      m_write(v, pf);
      chk(ready && acc_req == '0, "R5", "direct install", 64'({ready, acc_req}), 64'({1'b1, 4'b0}));
    end else begin
      chk(!ready && acc_req == e_mask, "R5", "accessed request", 64'({ready, acc_req}), 64'({1'b0, e_mask}));
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk(acc_req == e_mask, "R5", "request held", 64'(acc_req), 64'(e_mask));
        look(v, "R5");
      end
      @(negedge clk); ack = 1;
      @(posedge clk); #0.5; ack = 0;
      m_write(v, pf);
      chk(ready && acc_req == '0, "R5", "after ack", 64'({ready, acc_req}), 64'({1'b1, 4'b0}));
    end
    @(negedge clk);
    look(v, req);
  endtask

  task automatic do_inval(logic [VPN_W-1:0] v);
    @(negedge clk); inv = 1; inv_vpn = v;
    @(posedge clk); #0.5; inv = 0;
    for (int i = 0; i < ENTRIES; i++)
      if (mv[i] && (mbig[i] ? (mvpn[i][VPN_W-1:LP_BITS] == v[VPN_W-1:LP_BITS]) : (mvpn[i] == v)))
        mv[i] = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(posedge clk); #0.5; flush = 0;
    for (int i = 0; i < ENTRIES; i++) mv[i] = 0;
  endtask

  task automatic set_fill(logic [VPN_W-1:0] v, logic [PFN_W-1:0] pf, logic [3:0] p, logic [3:0] rs,
                          logic [3:0] a, logic [3:0] w, logic [3:0] u, logic [3:0] x, logic [3:0] b);
    f_vpn = v; f_pfn = pf; f_p = p; f_rsvd = rs; f_a = a; f_wr = w; f_usr = u; f_nx = x; f_big = b;
    f_dirty = 4'b0101; f_mt = {3'd4, 3'd3, 3'd2, 3'd1};
  endtask

  function automatic logic [VPN_W-1:0] rnd_vpn();
    return VPN_W'(($urandom % 4) << LP_BITS) | VPN_W'($urandom % 8);
  endfunction

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < ENTRIES; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(ready && acc_req == '0, "R10", "reset port", 64'({ready, acc_req}), 64'({1'b1, 4'b0}));
    look(20'h00123, "R10");

    // R1 all permissive, then one level denies write and another user
    set_fill(20'h00010, 24'hABC001, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0);
    do_fill(0, "R1");
    set_fill(20'h00011, 24'hABC002, 4'hF, 4'h0, 4'hF, 4'b1011, 4'b0111, 4'h0, 4'h0);
    do_fill(0, "R1");
    // R2 no-execute with enable off and on
    nxe = 0;
    set_fill(20'h00012, 24'hABC003, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 4'b0100, 4'h0);
    do_fill(0, "R2");
    nxe = 1;
    set_fill(20'h00013, 24'hABC004, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 4'b0100, 4'h0);
    do_fill(0, "R2");
    // R3 final at level 1; levels 2,3 carry bad flags that must be ignored
    set_fill(20'h00400, 24'h123456, 4'b0011, 4'b1100, 4'b0011, 4'b0011, 4'b0011, 4'b1000, 4'b0010);
    do_fill(0, "R3");
    // R7 large page hit by another low offset, frame low bits from lookup
    look(20'h004A7, "R7");
    // R4 rejected walks
    set_fill(20'h00020, 24'h000777, 4'b1011, 4'h0, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0);
    do_fill(0, "R4");
    set_fill(20'h00021, 24'h000778, 4'hF, 4'b0001, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0);
    do_fill(0, "R4");
    // R5 accessed flags requested, acknowledged after a delay
    set_fill(20'h00030, 24'h000999, 4'hF, 4'h0, 4'b1010, 4'hF, 4'hF, 4'h0, 4'h0);
    do_fill(2, "R5");
    // R8 invalidate the large page through an inner address, then flush
    do_inval(20'h00555);
    look(20'h00400, "R8");
    look(20'h00010, "R8");
    do_flush();
    look(20'h00010, "R8");
    // R9 fill nine pages: the ninth takes the round-robin slot
    for (int k = 0; k < ENTRIES + 1; k++) begin
      set_fill(VPN_W'(32'h1000 + k), PFN_W'(32'h500 + k), 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0);
      do_fill(0, "R9");
    end
    for (int k = 0; k < ENTRIES + 1; k++) look(VPN_W'(32'h1000 + k), "R9");
    // R9 refill of a present page reuses its slot
    set_fill(20'h01003, 24'h0FFFFF, 4'hF, 4'h0, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0);
    do_fill(0, "R9");
    do_flush();

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      r = $urandom % 10;
      if (r < 6) begin
        f_vpn = rnd_vpn(); f_pfn = PFN_W'($urandom);
        f_p = ($urandom % 8 == 0) ? ~(LEVELS'(1) << ($urandom % LEVELS)) : '1;
        f_rsvd = ($urandom % 10 == 0) ? (LEVELS'(1) << ($urandom % LEVELS)) : '0;
        f_a = LEVELS'($urandom); f_wr = LEVELS'($urandom | $urandom);
        f_usr = LEVELS'($urandom | $urandom); f_nx = LEVELS'($urandom & $urandom);
        f_big = ($urandom % 4 == 0) ? (LEVELS'(1) << (1 + $urandom % 2)) : '0;
        f_dirty = LEVELS'($urandom); f_mt = (LEVELS*MT_W)'($urandom);
        nxe = 1'($urandom);
        do_fill(int'($urandom % 3), "R6");
      end else if (r < 8) begin
        do_inval(rnd_vpn());
      end else if (r == 8 && ($urandom % 4 == 0)) begin
        do_flush();
      end
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        look(rnd_vpn(), "R6");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule